// File: doc/BRIEF.md
# Rolling-Code Frame Modulator

The block turns one prepared 69-bit rolling-code word into a timed waveform on a single output line. A frame has three parts. First comes a preamble of alternating high and low periods. Then comes a low header gap. Last come the 69 data bits, sent least significant bit first. Every period in the frame is a whole number of base element times (TE). A TE is a fixed count of system clocks, set by a parameter.

The surrounding logic supplies the inputs. The cipher output arrives as a 32-bit encrypted field. The fixed fields arrive separately: serial number, button state, low-voltage flag, CRC and queue bits. A one-clock start strobe launches a frame. The block captures all fields and both mode selects at that moment. One select chooses between pulse-width coding and Manchester coding. The other select picks a long or short header, and it applies only to pulse-width coding. A one-clock done pulse marks the end of the frame.

Top module: `code_frame_tx`

## Requirements
- R1: While reset is active, and afterwards until a start is accepted, `line_o` is low and `done_o` is low.
- R2: A frame begins with a preamble of 2*PRE_PAIRS TE slots. The slots alternate high and low, starting high in the clock after the start is sampled and ending low.
- R3: In pulse-width mode (`manch_i`=0), the low header gap is 10 TE when `hdr_short_i`=0 and 3 TE when `hdr_short_i`=1.
- R4: In Manchester mode (`manch_i`=1), the header gap is always 4 TE, whatever the value of `hdr_short_i`.
- R5: The word is sent least significant bit first and is laid out as follows:
  - bits 31:0 are `enc_i`;
  - bits 59:32 are `serial_i`;
  - bits 63:60 are `btn_i`, with `btn_i[0]` at bit 60;
  - bit 64 is `vlow_i`;
  - bits 66:65 are `crc_i`;
  - bits 68:67 are `queue_i`.
- R6: In pulse-width mode each bit takes 3 TE. A 1 is sent as high-low-low and a 0 as high-high-low.
- R7: In Manchester mode each bit takes 2 TE. A 1 is sent as low-high and a 0 as high-low.
- R8: Every TE slot lasts exactly TE_CYC clocks, and `line_o` changes only at slot boundaries.
- R9: A start strobe that arrives while a frame is in progress has no effect on the current frame. Changes to the field inputs during a frame also have no effect on it.
- R10: In the clock after the last data slot, `line_o` is low and `done_o` is high for exactly one clock. A start given in that done clock is accepted.
- R11: Both mode selects (`manch_i`, `hdr_short_i`) are captured at start. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, one clock |
| manch_i | input | 1 | 1 selects Manchester coding, 0 selects pulse-width coding |
| hdr_short_i | input | 1 | 1 selects the 3 TE pulse-width header |
| enc_i | input | 32 | Encrypted field |
| serial_i | input | 28 | Serial number |
| btn_i | input | 4 | Button state, fixed copy |
| vlow_i | input | 1 | Low-voltage flag |
| crc_i | input | 2 | CRC bits |
| queue_i | input | 2 | Queue bits |
| line_o | output | 1 | Modulated output line |
| done_o | output | 1 | End-of-frame pulse |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a frame. In that same clock the field inputs and both mode selects also change. The bench reaches this by pulsing `start_i` partway through a frame while it inverts the word inputs and flips both selects. The expected waveform for that frame is still the one built from the values captured at launch.

A second hard case is a start given in the single done clock. The driver reaches it by launching the next frame as soon as the scoreboard has consumed the done entry. No idle gap is left between the two frames.

// File: rtl/code_frame_tx_pkg.sv
package code_frame_tx_pkg;
  localparam int ENC_W  = 32;
  localparam int SER_W  = 28;
  localparam int BTN_W  = 4;
  localparam int WORD_W = ENC_W + SER_W + BTN_W + 1 + 2 + 2;
  localparam int BIDX_W = $clog2(WORD_W);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_HDR,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/cft_te_timer.sv
module cft_te_timer #(
  parameter int TE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (TE_CYC > 1) ? $clog2(TE_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(TE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= RELOAD;
    else if (!run_i || cnt_q == '0) cnt_q <= RELOAD;
    else                            cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/cft_word_packer.sv
module cft_word_packer
  import code_frame_tx_pkg::*;
(
  input  logic [ENC_W-1:0]  enc_i,
  input  logic [SER_W-1:0]  serial_i,
  input  logic [BTN_W-1:0]  btn_i,
  input  logic              vlow_i,
  input  logic [1:0]        crc_i,
  input  logic [1:0]        queue_i,
  output logic [WORD_W-1:0] word_o
);
  // lsb side goes out first
  assign word_o = {queue_i, crc_i, vlow_i, btn_i, serial_i, enc_i};
endmodule

// File: rtl/cft_frame_seq.sv
module cft_frame_seq
  import code_frame_tx_pkg::*;
#(
  parameter int PRE_PAIRS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              manch_i,
  input  logic              hdr_short_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              line_o,
  output logic              done_o
);
  localparam int PRE_TE   = 2 * PRE_PAIRS;
  localparam int MAX_SLOT = (PRE_TE > 10) ? PRE_TE : 10;
  localparam int SW       = $clog2(MAX_SLOT + 1);

  phase_e              phase_q;
  logic [SW-1:0]       slot_q;
  logic [BIDX_W-1:0]   bit_q;
  logic [WORD_W-1:0]   word_q;
  logic                manch_q;
  logic                short_q;
  logic                done_q;
  logic [SW-1:0]       last_slot;
  logic                cur_bit;

  assign cur_bit = word_q[bit_q];

  always_comb begin
    unique case (phase_q)
      PH_PRE:  last_slot = SW'(PRE_TE - 1);
      PH_HDR:  last_slot = manch_q ? SW'(3) : (short_q ? SW'(2) : SW'(9));
      PH_DATA: last_slot = manch_q ? SW'(1) : SW'(2);
      default: last_slot = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      bit_q   <= '0;
      word_q  <= '0;
      manch_q <= 1'b0;
      short_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          phase_q <= PH_PRE;
          slot_q  <= '0;
          bit_q   <= '0;
          word_q  <= word_i;
          manch_q <= manch_i;
          short_q <= hdr_short_i;
        end
      end else if (tick_i) begin
        if (slot_q == last_slot) begin
          slot_q <= '0;
          unique case (phase_q)
            PH_PRE: phase_q <= PH_HDR;
            PH_HDR: phase_q <= PH_DATA;
            default: begin
              if (bit_q == BIDX_W'(WORD_W - 1)) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          endcase
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_PRE:  line_o = ~slot_q[0];
      PH_DATA: begin
        if (manch_q) line_o = (slot_q == '0) ? ~cur_bit : cur_bit;
        else         line_o = (slot_q == '0) || ((slot_q == SW'(1)) && !cur_bit);
      end
      default: line_o = 1'b0;
    endcase
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/code_frame_tx.sv
module code_frame_tx
  import code_frame_tx_pkg::*;
#(
  parameter int TE_CYC    = 4,
  parameter int PRE_PAIRS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             manch_i,
  input  logic             hdr_short_i,
  input  logic [ENC_W-1:0] enc_i,
  input  logic [SER_W-1:0] serial_i,
  input  logic [BTN_W-1:0] btn_i,
  input  logic             vlow_i,
  input  logic [1:0]       crc_i,
  input  logic [1:0]       queue_i,
  output logic             line_o,
  output logic             done_o
);
  logic [WORD_W-1:0] word_w;
  logic              busy_w;
  logic              tick_w;

  cft_word_packer u_pack (
    .enc_i    (enc_i),
    .serial_i (serial_i),
    .btn_i    (btn_i),
    .vlow_i   (vlow_i),
    .crc_i    (crc_i),
    .queue_i  (queue_i),
    .word_o   (word_w)
  );

  cft_te_timer #(.TE_CYC(TE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .tick_o (tick_w)
  );

  cft_frame_seq #(.PRE_PAIRS(PRE_PAIRS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .manch_i     (manch_i),
    .hdr_short_i (hdr_short_i),
    .word_i      (word_w),
    .tick_i      (tick_w),
    .busy_o      (busy_w),
    .line_o      (line_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/code_frame_tx_chk.sv
module code_frame_tx_chk #(
  parameter int TE_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic line_o,
  input logic done_o,
  input logic busy_i,
  input logic tick_i
);
  localparam int GW = $clog2(TE_CYC + 1);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= '0;
    else if (!busy_i || tick_i) gap_q <= '0;
    else                        gap_q <= gap_q + 1'b1;
  end

  assert_slot_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (gap_q == GW'(TE_CYC - 1)));

  assert_slot_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$past(tick_i)) |-> $stable(line_o));

  assert_pre_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> line_o);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!line_o && $past(busy_i)));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i && !tick_i) |=> busy_i);

  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !line_o);
endmodule

bind code_frame_tx code_frame_tx_chk #(.TE_CYC(TE_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .line_o  (line_o),
  .done_o  (done_o),
  .busy_i  (busy_w),
  .tick_i  (tick_w)
);

// File: tb/code_frame_tx_tb.sv
module code_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TE_CYC     = 4;
  localparam int PRE_PAIRS  = 6;

  typedef struct {
    bit    line;
    bit    done;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        manch = 1'b0;
  logic        hshort = 1'b0;
  logic [31:0] enc = '0;
  logic [27:0] ser = '0;
  logic [3:0]  btn = '0;
  logic        vlow = 1'b0;
  logic [1:0]  crc = '0;
  logic [1:0]  que = '0;
  logic        line;
  logic        done;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  code_frame_tx #(.TE_CYC(TE_CYC), .PRE_PAIRS(PRE_PAIRS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .manch_i(manch),
    .hdr_short_i(hshort), .enc_i(enc), .serial_i(ser), .btn_i(btn),
    .vlow_i(vlow), .crc_i(crc), .queue_i(que), .line_o(line), .done_o(done)
  );

  // monitor: per-clock compare, which also covers slot length (R8)
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (line !== it.line || done !== it.done) begin
        errors++;
        $display("FAIL %s R8: line=%b done=%b expected line=%b done=%b at %0t",
                 it.req, line, done, it.line, it.done, $time);
      end
    end
  end

  task automatic push_slot(bit lvl, string req);
    for (int k = 0; k < TE_CYC; k++) exp_q.push_back('{lvl, 1'b0, req});
  endtask

  // called at a negedge; returns at a negedge once the scoreboard drains
  task automatic send(bit m, bit s, bit [31:0] e, bit [27:0] sn, bit [3:0] b,
                      bit v, bit [1:0] c, bit [1:0] q, int glitch_at, int idle_after);
    bit [68:0] w;
    int        hl;
    string     t;
    manch = m; hshort = s; enc = e; ser = sn; btn = b; vlow = v; crc = c; que = q;
    start = 1'b1;
    w = {q, c, v, b, sn, e}; // R5 layout
    @(posedge clk);
    for (int k = 0; k < 2*PRE_PAIRS; k++)
      push_slot((k % 2) == 0, (glitch_at > 0) ? "R9" : "R2");
    hl = m ? 4 : (s ? 3 : 10);
    t  = (glitch_at > 0) ? "R11" : (m ? "R4" : "R3");
    for (int k = 0; k < hl; k++) push_slot(1'b0, t);
    for (int i = 0; i < 69; i++) begin
      t = (glitch_at > 0) ? "R9 R5" : (m ? "R7 R5" : "R6 R5");
      if (m) begin
        push_slot(!w[i], t);
        push_slot(w[i], t);
      end else begin
        push_slot(1'b1, t);
        push_slot(!w[i], t);
        push_slot(1'b0, t);
      end
    end
    exp_q.push_back('{1'b0, 1'b1, "R10"});
    for (int k = 0; k < idle_after; k++) exp_q.push_back('{1'b0, 1'b0, "R10"});
    @(negedge clk);
    start = 1'b0;
    if (glitch_at > 0) begin
      repeat (glitch_at) @(negedge clk);
      start = 1'b1; manch = ~m; hshort = ~s; enc = ~e; ser = ~sn; btn = ~b;
      vlow = ~v; crc = ~c; que = ~q;
      @(negedge clk);
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (line !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset line=%b done=%b expected 0 0", line, done);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (line !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: idle line=%b done=%b expected 0 0", line, done);
    end
    // PWM long header, R3 R6
    send(1'b0, 1'b0, 32'hA5C3_0F96, 28'h1234567, 4'b1001, 1'b1, 2'b10, 2'b01, 0, 3);
    // PWM short header
    send(1'b0, 1'b1, 32'h0000_0001, 28'hFFFFFFF, 4'b0110, 1'b0, 2'b01, 2'b10, 0, 3);
    // Manchester, both header selects, R4 R7
    send(1'b1, 1'b0, 32'hDEAD_BEEF, 28'h0F0F0F0, 4'b1100, 1'b1, 2'b11, 2'b00, 0, 3);
    send(1'b1, 1'b1, 32'h8000_0000, 28'h0000001, 4'b0011, 1'b0, 2'b00, 2'b11, 0, 2);
    // mid-frame start and input changes, R9 R11
    send(1'b0, 1'b1, 32'h1357_9BDF, 28'h2468ACE, 4'b1010, 1'b1, 2'b01, 2'b01, 60, 2);
    send(1'b1, 1'b0, 32'hCAFE_F00D, 28'h5A5A5A5, 4'b0101, 1'b0, 2'b10, 2'b10, 250, 0);
    // back-to-back: start in the done clock, R10
    send(1'b0, 1'b0, 32'h7F00_FF01, 28'h0ABCDEF, 4'b1111, 1'b1, 2'b11, 2'b11, 0, 0);
    send(1'b1, 1'b1, 32'h0123_4567, 28'h89ABCDE, 4'b0000, 1'b1, 2'b00, 2'b01, 0, 4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected end of test");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule